// File: doc/BRIEF.md
# Command-Driven Full-Duplex SPI Transactor

This block sits behind a control-endpoint handler. It receives each 8-byte setup packet as a single parallel word with a one-cycle valid strobe. One vendor read command selects it. The packet carries up to four outgoing bytes, a peripheral-select mask and a byte count, all inside the value, index and length fields. The block checks these arguments. It then runs a full-duplex SPI exchange on the selected peripheral, shifting most-significant bit first, and sampling MISO while SCLK is high.

Each byte received over MISO overwrites, bit by bit, the byte that was sent from the same slot of a four-slot buffer. At the end the buffer holds the reply the host reads back. When the run completes, a one-cycle done pulse reports success and the number of valid reply bytes. A request whose arguments are bad gets a failure pulse on the next cycle and causes no bus activity. The SCLK half-period is set in system clocks by a live divider input.

Top module: `spi_cmd_xact`

## Requirements
- R1: A request is taken only when packet byte 0 (`setupPkt[7:0]`) is 0x80 and byte 1 (`setupPkt[15:8]`) is 0x83. Any other packet produces no done pulse, no SCLK edge and no select; packet byte k is `setupPkt[8k+7:8k]`.
- R2: Slot 0 is loaded from packet byte 3 (value high) and slot 1 from byte 2 (value low). Slot 2 is loaded from byte 5 (index high) and slot 3 from byte 4 (index low). Slot s appears on `resultBytes[8s+7:8s]`.
- R3: Byte 7 is the select mask and byte 6 is the byte count. A mask with more than one bit set is rejected. On rejection `donePulse` rises on the clock after the request, with `doneOk`=0 and `doneCount`=0, and there are no SCLK edges and no select.
- R4: A count above 4 is rejected in the same way. A count of 0 gives `donePulse` on the clock after the request, with `doneOk`=1 and `doneCount`=0, and no SCLK edges.
- R5: A count of n from 1 to 4 produces exactly 8n rising SCLK edges. The bits on MOSI come from slot 0 first and then the following slots in order, most-significant bit first within each byte.
- R6: MOSI changes only while SCLK is low, and SCLK idles low when the block is not busy. Each high phase and each low phase between rising edges lasts max(`halfPeriod`,1) clocks, and MISO is sampled at the end of the high phase.
- R7: After a run of n bytes, each slot below n holds the byte that was received during that slot, MSB first. Slots n and above keep their transmit byte.
- R8: `csN` is the inverse of the mask for the whole run and at every rising SCLK edge. All `csN` bits are high when the block is idle, and at most one bit is ever low.
- R9: `donePulse` lasts exactly one clock and comes when the block is not busy. After a run it carries `doneOk`=1 and `doneCount`=n.
- R10: A request presented while `busy` is high is ignored. It causes no extra done pulse and no change to the result or the select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| setupValid | input | 1 | Setup packet valid strobe, one cycle |
| setupPkt | input | 64 | Setup packet, byte k at bits 8k+7:8k |
| halfPeriod | input | DIV_W | SCLK half-period in clocks (0 treated as 1) |
| misoIn | input | 1 | Serial data from peripheral |
| sclkOut | output | 1 | Serial clock, idles low |
| mosiOut | output | 1 | Serial data to peripheral |
| csN | output | 8 | Active-low peripheral selects |
| busy | output | 1 | Transaction in progress |
| donePulse | output | 1 | One-cycle completion strobe |
| doneOk | output | 1 | 1 = success, 0 = rejected |
| doneCount | output | 3 | Number of valid result bytes |
| resultBytes | output | 32 | Four result slots, slot 0 in the low byte |

## Verification
The bench targets the swapped byte pairs in the value and index fields; a design that mapped them straight would put bytes in the wrong order on MOSI and in the result. It sends an empty mask, a two-bit mask, a full mask, and counts of 0, 4 and 5. A design that counted mask bits wrongly or used `>=` in the length check would clock the bus for a request it should refuse, or refuse one it should run. It sets the divider to zero and to several other values to expose an off-by-one in the phase length. It also sends a second request in the middle of a run, which a design that lacked the busy guard would accept, reloading the buffer and moving the select.

// File: rtl/spix_pkg.sv
package spix_pkg;
  localparam int SLOTS  = 4;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 8;
  localparam int SLOT_IDX_W = $clog2(SLOTS);
  localparam int COUNT_W    = $clog2(SLOTS) + 1;
  localparam logic [7:0] REQ_TYPE_IN = 8'h80;
  localparam logic [7:0] REQ_CODE    = 8'h83;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } xferState_t;

  typedef struct packed {
    logic                  load;
    logic                  shiftBit;
    logic [SLOT_IDX_W-1:0] slotSel;
    logic                  selOn;
    logic                  selOff;
    logic                  clkHigh;
    logic                  clkLow;
  } dpCtl_t;
endpackage

// File: rtl/spix_decode.sv
module spix_decode
  import spix_pkg::*;
(
  input  logic [63:0]                 setupPkt,
  output logic                        isCmd,
  output logic [SLOTS*BYTE_W-1:0]     txBytes,
  output logic [SEL_W-1:0]            selMask,
  output logic [7:0]                  byteCount,
  output logic                        argsOk
);
  logic [7:0] pktByte [8];
  logic [3:0] maskOnes;

  genvar k;
  generate
    for (k = 0; k < 8; k++) begin : g_bytes
      assign pktByte[k] = setupPkt[8*k +: 8];
    end
  endgenerate

  assign isCmd     = (pktByte[0] == REQ_TYPE_IN) && (pktByte[1] == REQ_CODE);
  assign selMask   = pktByte[7];
  assign byteCount = pktByte[6];

  // Value and index fields are little-endian words; high byte goes first.
  assign txBytes[0*BYTE_W +: BYTE_W] = pktByte[3];
  assign txBytes[1*BYTE_W +: BYTE_W] = pktByte[2];
  assign txBytes[2*BYTE_W +: BYTE_W] = pktByte[5];
  assign txBytes[3*BYTE_W +: BYTE_W] = pktByte[4];

  always_comb begin
    maskOnes = '0;
    for (int b = 0; b < SEL_W; b++) maskOnes = maskOnes + {3'b000, selMask[b]};
  end

  assign argsOk = (maskOnes <= 4'd1) && (byteCount <= 8'(SLOTS));
endmodule

// File: rtl/spix_ctrl.sv
module spix_ctrl
  import spix_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               argsOk,
  input  logic [7:0]         byteCount,
  input  logic [DIV_W-1:0]   halfPeriod,
  output dpCtl_t             ctl,
  output logic               busy,
  output logic               donePulse,
  output logic               doneOk,
  output logic [COUNT_W-1:0] doneCount
);
  xferState_t            state;
  logic [DIV_W-1:0]      phaseCnt;
  logic [2:0]            bitIdx;
  logic [SLOT_IDX_W-1:0] slotIdx;
  logic [SLOT_IDX_W-1:0] lastSlot;
  logic [COUNT_W-1:0]    savedCount;
  logic [DIV_W-1:0]      hpEff;
  logic                  phaseEnd;
  logic                  lastBit;
  logic                  startRun;

  assign hpEff    = (halfPeriod == '0) ? DIV_W'(1) : halfPeriod;
  assign phaseEnd = (phaseCnt >= hpEff - DIV_W'(1));
  assign lastBit  = (bitIdx == 3'd7) && (slotIdx == lastSlot);
  assign startRun = reqValid && argsOk && (byteCount != 8'd0);
  assign busy     = (state != ST_IDLE);

  always_comb begin
    ctl         = '0;
    ctl.slotSel = slotIdx;
    unique case (state)
      ST_IDLE: begin
        ctl.load  = startRun;
        ctl.selOn = startRun;
      end
      ST_LOW:  ctl.clkHigh = phaseEnd;
      ST_HIGH: begin
        ctl.shiftBit = phaseEnd;
        ctl.clkLow   = phaseEnd;
        ctl.selOff   = phaseEnd && lastBit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phaseCnt   <= '0;
      bitIdx     <= '0;
      slotIdx    <= '0;
      lastSlot   <= '0;
      savedCount <= '0;
      donePulse  <= 1'b0;
      doneOk     <= 1'b0;
      doneCount  <= '0;
    end else begin
      donePulse <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (!argsOk) begin
              donePulse <= 1'b1;
              doneOk    <= 1'b0;
              doneCount <= '0;
            end else if (byteCount == 8'd0) begin
              donePulse <= 1'b1;
              doneOk    <= 1'b1;
              doneCount <= '0;
            end else begin
              state      <= ST_LOW;
              phaseCnt   <= '0;
              bitIdx     <= '0;
              slotIdx    <= '0;
              lastSlot   <= SLOT_IDX_W'(byteCount[SLOT_IDX_W-1:0] - 1'b1);
              savedCount <= byteCount[COUNT_W-1:0];
            end
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            state    <= ST_HIGH;
          end else begin
            phaseCnt <= phaseCnt + DIV_W'(1);
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            phaseCnt <= '0;
            if (lastBit) begin
              state <= ST_DONE;
            end else begin
              state <= ST_LOW;
              if (bitIdx == 3'd7) begin
                bitIdx  <= '0;
                slotIdx <= slotIdx + SLOT_IDX_W'(1);
              end else begin
                bitIdx <= bitIdx + 3'd1;
              end
            end
          end else begin
            phaseCnt <= phaseCnt + DIV_W'(1);
          end
        end
        ST_DONE: begin
          donePulse <= 1'b1;
          doneOk    <= 1'b1;
          doneCount <= savedCount;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spix_datapath.sv
module spix_datapath
  import spix_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  dpCtl_t                  ctl,
  input  logic [SLOTS*BYTE_W-1:0] txBytes,
  input  logic [SEL_W-1:0]        selMask,
  input  logic                    misoIn,
  output logic                    sclkOut,
  output logic                    mosiOut,
  output logic [SEL_W-1:0]        csN,
  output logic [SLOTS*BYTE_W-1:0] resultBytes
);
  logic [SLOTS-1:0][BYTE_W-1:0] slotBus;

  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_slot
      logic [BYTE_W-1:0] slotQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          slotQ <= '0;
        end else if (ctl.load) begin
          slotQ <= txBytes[s*BYTE_W +: BYTE_W];
        end else if (ctl.shiftBit && (ctl.slotSel == SLOT_IDX_W'(s))) begin
          // rotate: top bit has gone out on MOSI, received bit enters bottom
          slotQ <= {slotQ[BYTE_W-2:0], misoIn};
        end
      end
      assign slotBus[s] = slotQ;
      assign resultBytes[s*BYTE_W +: BYTE_W] = slotQ;
    end
  endgenerate

  assign mosiOut = slotBus[ctl.slotSel][BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkOut <= 1'b0;
      csN     <= '1;
    end else begin
      if (ctl.clkHigh)     sclkOut <= 1'b1;
      else if (ctl.clkLow) sclkOut <= 1'b0;
      if (ctl.selOn)       csN <= ~selMask;
      else if (ctl.selOff) csN <= '1;
    end
  end
endmodule

// File: rtl/spi_cmd_xact.sv
module spi_cmd_xact
  import spix_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               setupValid,
  input  logic [63:0]        setupPkt,
  input  logic [DIV_W-1:0]   halfPeriod,
  input  logic               misoIn,
  output logic               sclkOut,
  output logic               mosiOut,
  output logic [7:0]         csN,
  output logic               busy,
  output logic               donePulse,
  output logic               doneOk,
  output logic [2:0]         doneCount,
  output logic [31:0]        resultBytes
);
  logic                    isCmd;
  logic [SLOTS*BYTE_W-1:0] txBytes;
  logic [SEL_W-1:0]        selMask;
  logic [7:0]              byteCount;
  logic                    argsOk;
  dpCtl_t                  ctl;

  spix_decode u_decode (
    .setupPkt  (setupPkt),
    .isCmd     (isCmd),
    .txBytes   (txBytes),
    .selMask   (selMask),
    .byteCount (byteCount),
    .argsOk    (argsOk)
  );

  spix_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (setupValid && isCmd),
    .argsOk     (argsOk),
    .byteCount  (byteCount),
    .halfPeriod (halfPeriod),
    .ctl        (ctl),
    .busy       (busy),
    .donePulse  (donePulse),
    .doneOk     (doneOk),
    .doneCount  (doneCount)
  );

  spix_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .txBytes     (txBytes),
    .selMask     (selMask),
    .misoIn      (misoIn),
    .sclkOut     (sclkOut),
    .mosiOut     (mosiOut),
    .csN         (csN),
    .resultBytes (resultBytes)
  );
endmodule

// File: rtl/spix_checker.sv
module spix_checker (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       sclkOut,
  input logic       mosiOut,
  input logic [7:0] csN,
  input logic       donePulse,
  input logic       doneOk,
  input logic [2:0] doneCount
);
  a_r8_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  a_r8_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (csN == 8'hFF));

  a_r6_idle_clock_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclkOut);

  a_r6_mosi_steady_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOut && $past(sclkOut)) |-> $stable(mosiOut));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy);

  a_r3_reject_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (donePulse && !doneOk) |-> (doneCount == 3'd0));

  a_r4_count_limit: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> (doneCount <= 3'd4));
endmodule

bind spi_cmd_xact spix_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .sclkOut   (sclkOut),
  .mosiOut   (mosiOut),
  .csN       (csN),
  .donePulse (donePulse),
  .doneOk    (doneOk),
  .doneCount (doneCount)
);

// File: tb/sim_spi_cmd_xact.sv
module sim_spi_cmd_xact;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        setupValid = 1'b0;
  logic [63:0] setupPkt = '0;
  logic [7:0]  halfPeriod = 8'd1;
  logic        misoIn = 1'b0;
  logic        sclkOut, mosiOut, busy, donePulse, doneOk;
  logic [7:0]  csN;
  logic [2:0]  doneCount;
  logic [31:0] resultBytes;

  spi_cmd_xact #(.DIV_W(8)) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int riseCount = 0;
  int doneSeen = 0;
  int csBad = 0;
  int widthBad = 0;
  int lastRise = -1;
  int lastFall = -1;
  int expW = 1;
  int slvIdx = 0;
  logic [7:0]  expCs = 8'hFF;
  logic [31:0] rxShift = '0;
  logic [31:0] slvData = '0;

  // {mask, count, tx(slot3..slot0), slave(slot3..slot0), halfPeriod}
  localparam logic [87:0] VEC [10] = '{
    {8'h01, 8'd1, 32'h000000A5, 32'h0000003C, 8'd1},
    {8'h04, 8'd4, 32'h12345678, 32'hCAFEF00D, 8'd2},
    {8'h80, 8'd2, 32'h0000FF00, 32'h0000817E, 8'd3},
    {8'h00, 8'd3, 32'h00C3E1F0, 32'h0055AA0F, 8'd0},
    {8'h03, 8'd2, 32'h11223344, 32'h00000000, 8'd1},
    {8'h10, 8'd5, 32'h55667788, 32'h00000000, 8'd1},
    {8'h02, 8'd0, 32'h99AABBCC, 32'h00000000, 8'd1},
    {8'h40, 8'd4, 32'hFFFFFFFF, 32'h00000000, 8'd5},
    {8'h20, 8'd3, 32'h80018001, 32'h01800180, 8'd1},
    {8'hFF, 8'd4, 32'hDEADBEEF, 32'h00000000, 8'd1}
  };

  function automatic logic [63:0] mkPkt(input logic [7:0] rt, input logic [7:0] rq,
      input logic [31:0] tx, input logic [7:0] mask, input logic [7:0] cnt);
    return {mask, cnt, tx[23:16], tx[31:24], tx[7:0], tx[15:8], rq, rt};
  endfunction

  function automatic logic misoBit(input logic [31:0] d, input int n);
    if (n > 31) return 1'b0;
    return d[8*(n/8) + 7 - (n%8)];
  endfunction

  function automatic int onesOf(input logic [7:0] m);
    int c = 0;
    for (int b = 0; b < 8; b++) c += m[b];
    return c;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;
  always @(negedge clk) if (donePulse) doneSeen++;

  always @(posedge sclkOut) begin
    riseCount++;
    rxShift = {rxShift[30:0], mosiOut};
    if (csN !== expCs) csBad++;
    if (lastFall >= 0 && (cyc - lastFall) != expW) widthBad++;
    lastRise = cyc;
  end

  always @(negedge sclkOut) begin
    if (lastRise >= 0 && (cyc - lastRise) != expW) widthBad++;
    lastFall = cyc;
    slvIdx++;
    misoIn = misoBit(slvData, slvIdx);
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic prepRun(input logic [7:0] mask, input logic [31:0] slv, input logic [7:0] hp);
    riseCount = 0; csBad = 0; widthBad = 0; lastRise = -1; lastFall = -1;
    rxShift = '0; slvData = slv; slvIdx = 0; misoIn = misoBit(slv, 0);
    expCs = ~mask; expW = (hp == 0) ? 1 : int'(hp); halfPeriod = hp;
  endtask

  task automatic sendReq(input logic [63:0] pkt);
    @(negedge clk);
    setupPkt = pkt; setupValid = 1'b1;
    @(negedge clk);
    setupValid = 1'b0;
  endtask

  task automatic waitDone(output int waited);
    waited = 0;
    while (!donePulse && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
  endtask

  initial begin
    int waited;
    int doneBase;
    logic [31:0] expRx, expRes, prevRes;
    repeat (3) @(negedge clk);
    // R8 R6 R9 reset state
    check("R8 reset csN", csN, 8'hFF);
    check("R6 reset sclk", sclkOut, 0);
    check("R9 reset done", {busy, donePulse}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 10; v++) begin
      logic [7:0] mask, cnt, hp;
      logic [31:0] tx, slv;
      logic good;
      {mask, cnt, tx, slv, hp} = VEC[v];
      good = (onesOf(mask) <= 1) && (cnt <= 4);
      prevRes = resultBytes;
      prepRun(mask, slv, hp);
      doneBase = doneSeen;
      sendReq(mkPkt(8'h80, 8'h83, tx, mask, cnt));
      waitDone(waited);
      check($sformatf("R9 done v%0d", v), donePulse, 1);
      check($sformatf("R3 R4 ok v%0d", v), doneOk, good);
      check($sformatf("R9 count v%0d", v), doneCount, good ? cnt : 0);
      check($sformatf("R5 edges v%0d", v), riseCount, good ? 8*cnt : 0);
      if (!good || cnt == 0) begin
        check($sformatf("R3 R4 immediate v%0d", v), waited, 0);
        check($sformatf("R7 untouched v%0d", v), resultBytes, prevRes);
      end else begin
        expRx = '0; expRes = tx;
        for (int s = 0; s < 4; s++) if (s < cnt) begin
          expRx = {expRx[23:0], tx[8*s +: 8]};
          expRes[8*s +: 8] = slv[8*s +: 8];
        end
        check($sformatf("R2 R5 mosi v%0d", v), rxShift, expRx);
        check($sformatf("R7 result v%0d", v), resultBytes, expRes);
        check($sformatf("R8 select v%0d", v), csBad, 0);
        check($sformatf("R6 widths v%0d", v), widthBad, 0);
      end
      @(negedge clk);
      check($sformatf("R9 single v%0d", v), doneSeen - doneBase, 1);
      check($sformatf("R8 idle csN v%0d", v), csN, 8'hFF);
    end

    // R1: wrong request type and wrong request code are ignored
    prevRes = resultBytes;
    prepRun(8'h01, 32'h0, 8'd1);
    doneBase = doneSeen;
    sendReq(mkPkt(8'hC0, 8'h83, 32'h01020304, 8'h01, 8'd2));
    sendReq(mkPkt(8'h80, 8'h84, 32'h01020304, 8'h01, 8'd2));
    repeat (30) @(negedge clk);
    check("R1 no done", doneSeen - doneBase, 0);
    check("R1 no edges", riseCount, 0);
    check("R1 no select", {busy, csN}, {1'b0, 8'hFF});
    check("R1 result kept", resultBytes, prevRes);

    // R10: second request during a run is ignored
    prepRun(8'h08, 32'h0F1E2D3C, 8'd4);
    doneBase = doneSeen;
    sendReq(mkPkt(8'h80, 8'h83, 32'hA1B2C3D4, 8'h08, 8'd4));
    repeat (10) @(negedge clk);
    check("R10 busy", busy, 1);
    sendReq(mkPkt(8'h80, 8'h83, 32'h55555555, 8'h01, 8'd1));
    waitDone(waited);
    check("R10 result", resultBytes, 32'h0F1E2D3C);
    check("R10 select", csBad, 0);
    check("R10 mosi", rxShift, 32'hD4C3B2A1);
    repeat (40) @(negedge clk);
    check("R10 one done", doneSeen - doneBase, 1);
    check("R10 edges", riseCount, 32);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule